// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second operand of an integer ALU from a register value. It takes the 8-bit shift-control field of a data-processing instruction, the operand register value, the value of a second register that can supply the shift amount, and the current carry flag. From these it produces the shifted operand and the shifter carry-out that the flag logic uses. It is purely combinational, so its outputs follow its inputs within the same cycle.

The control field names one of four shift kinds. The amount comes either from a 5-bit constant in the field or from the low byte of the second register. A few amounts have special meanings. A constant amount of zero means pass-through for a left shift, a full-width shift for the two right shifts, and a one-bit rotate through the carry for a rotate. A register amount of zero always passes the value through. Register amounts of 32 and above saturate, except for rotates, which wrap. The carry-out is always the last bit that left the operand, or the incoming carry when nothing moved. A separate flag marks the illegal choice of the program counter (register index 15) as the amount register.

Internally a decoder reduces the field to a mode, which is one of pass-through (`SM_PASS`), rotate through carry (`SM_RRX`) or a counted shift (`SM_SHIFT`), together with an effective amount. A shift core then applies that mode. No state is held, so the block has no states and no transitions.

Top module: `opnd_shifter`

## Requirements
- R1: Field decode: bit 0 picks the amount source (0 constant, 1 register); bits 2:1 pick the kind (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right); bits 7:3 are the constant amount; bits 7:4 are the register index. In register form only `rs_val[7:0]` sets the amount, and the upper 24 bits of `rs_val` have no effect.
- R2: A left logical shift by n in 1..31 gives `op_val << n`, with carry-out equal to `op_val[32-n]`.
- R3: A right logical or right arithmetic shift by n in 1..31 gives the shifted value (zero fill or sign fill), with carry-out equal to `op_val[n-1]`.
- R4: A rotate right by a nonzero amount n rotates by n mod 32. When n mod 32 is 0, the value is unchanged and the carry-out is `op_val[31]`; otherwise the carry-out is `op_val[(n mod 32)-1]`.
- R5: A constant-form left shift with amount 0 passes `op_val` through, and the carry-out equals `carry_in`.
- R6: A constant-form right logical or right arithmetic shift with amount 0 acts as a shift by 32. The logical shift gives 0 and the arithmetic shift gives 32 copies of bit 31. In both cases the carry-out is `op_val[31]`.
- R7: A constant-form rotate with amount 0 gives `{carry_in, op_val[31:1]}`, with carry-out equal to `op_val[0]`.
- R8: A register-form amount of 0 passes `op_val` through, with carry-out equal to `carry_in`, for every kind.
- R9: A register-form left or right logical shift by 32 gives 0, with carry-out `op_val[0]` (left) or `op_val[31]` (right). An amount above 32 gives 0 with carry-out 0.
- R10: A register-form right arithmetic shift by 32 or more gives 32 copies of bit 31, with carry-out equal to `op_val[31]`.
- R11: `rs_illegal` is 1 exactly when the field is in register form and bits 7:4 equal 15. In that case the value and the carry-out are still computed from `rs_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_val | input | 32 | Operand register value to be shifted |
| shf_field | input | 8 | Shift-control field of the instruction |
| rs_val | input | 32 | Amount register value; only its low byte is used |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out for the flag logic |
| rs_illegal | output | 1 | Set when the program counter is named as the amount register |

## Verification
Two functions can fall in the same cycle: the illegal-register flag and a normal register-form shift, since a field that names register 15 still carries a kind and an amount byte. The bench provokes this by sweeping every kind over several amount bytes with index 15. It judges each vector twice, checking the flag against the index rule and checking the value and carry-out against its bit-serial model. A second overlap is the constant-form rotate through carry, where `carry_in` and the operand both feed the result. It is covered by sweeping both carry values against every operand pattern.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        SM_PASS  = 2'b00,
        SM_RRX   = 2'b01,
        SM_SHIFT = 2'b10
    } shift_mode_e;

    typedef struct packed {
        shift_kind_e kind;
        shift_mode_e mode;
        logic [7:0]  amt;
    } shift_req_t;

endpackage

// File: rtl/opnd_shift_decode.sv
module opnd_shift_decode
    import opnd_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 8,
    parameter int BYTE_W = 8,
    parameter int PC_IDX = 15
) (
    input  logic [FLD_W-1:0]  fld,
    input  logic [BYTE_W-1:0] rs_byte,
    output shift_req_t        req,
    output logic              illegal
);
    localparam int IMM_W = FLD_W - 3;
    localparam int IDX_W = FLD_W - 4;

    logic [IMM_W-1:0] imm_amt;
    logic [IDX_W-1:0] rs_idx;
    logic             reg_form;

    assign imm_amt  = fld[FLD_W-1:3];
    assign rs_idx   = fld[FLD_W-1:4];
    assign reg_form = fld[0];

    always_comb begin
        req.kind = shift_kind_e'(fld[2:1]);
        req.mode = SM_SHIFT;
        req.amt  = '0;
        if (!reg_form) begin
            if (imm_amt == '0) begin
                unique case (req.kind)
                    SK_LSL:         req.mode = SM_PASS;
                    SK_LSR, SK_ASR: req.amt  = BYTE_W'(DATA_W);
                    SK_ROR:         req.mode = SM_RRX;
                endcase
            end else begin
                req.amt = BYTE_W'(imm_amt);
            end
        end else if (rs_byte == '0) begin
            req.mode = SM_PASS;
        end else begin
            req.amt = rs_byte;
        end
    end

    assign illegal = reg_form && (rs_idx == IDX_W'(PC_IDX));

endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core
    import opnd_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] op,
    input  shift_req_t        req,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int SH_W = $clog2(DATA_W);
    localparam int MSB  = DATA_W - 1;

    logic [SH_W-1:0] rot;
    logic [SH_W-1:0] lo_idx;
    logic            in_range;
    logic            at_width;

    assign rot      = req.amt[SH_W-1:0];
    assign lo_idx   = rot - SH_W'(1);
    assign in_range = (int'(req.amt) < DATA_W);
    assign at_width = (int'(req.amt) == DATA_W);

    always_comb begin
        res  = op;
        cout = cin;
        unique case (req.mode)
            SM_PASS: begin
                res  = op;
                cout = cin;
            end
            SM_RRX: begin
                res  = {cin, op[MSB:1]};
                cout = op[0];
            end
            SM_SHIFT: begin
                unique case (req.kind)
                    SK_LSL: begin
                        if (in_range) begin
                            res  = op << rot;
                            cout = op[SH_W'(DATA_W - int'(rot))];
                        end else begin
                            res  = '0;
                            cout = at_width ? op[0] : 1'b0;
                        end
                    end
                    SK_LSR: begin
                        if (in_range) begin
                            res  = op >> rot;
                            cout = op[lo_idx];
                        end else begin
                            res  = '0;
                            cout = at_width ? op[MSB] : 1'b0;
                        end
                    end
                    SK_ASR: begin
                        if (in_range) begin
                            res  = DATA_W'($signed(op) >>> rot);
                            cout = op[lo_idx];
                        end else begin
                            res  = {DATA_W{op[MSB]}};
                            cout = op[MSB];
                        end
                    end
                    SK_ROR: begin
                        if (rot == '0) begin
                            res  = op;
                            cout = op[MSB];
                        end else begin
                            res  = (op >> rot) | (op << (SH_W'(DATA_W - int'(rot))));
                            cout = op[lo_idx];
                        end
                    end
                endcase
            end
            default: begin
                res  = op;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opnd_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] op_val,
    input  logic [FLD_W-1:0]  shf_field,
    input  logic [DATA_W-1:0] rs_val,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              rs_illegal
);
    shift_req_t req;

    opnd_shift_decode #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .BYTE_W (BYTE_W),
        .PC_IDX (15)
    ) u_decode (
        .fld     (shf_field),
        .rs_byte (rs_val[BYTE_W-1:0]),
        .req     (req),
        .illegal (rs_illegal)
    );

    opnd_shift_core #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_core (
        .op   (op_val),
        .req  (req),
        .cin  (carry_in),
        .res  (result),
        .cout (carry_out)
    );

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 8
) (
    input logic [DATA_W-1:0] op_val,
    input logic [FLD_W-1:0]  shf_field,
    input logic [DATA_W-1:0] rs_val,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              rs_illegal
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        // R11
        if (rs_illegal) begin
            illegal_idx_chk: assert (shf_field[0] && shf_field[7:4] == 4'hF);
        end
        // R8
        if (shf_field[0] && rs_val[7:0] == 8'd0) begin
            reg_zero_pass_chk: assert (result == op_val && carry_out == carry_in);
        end
        // R5
        if (!shf_field[0] && shf_field[7:3] == 5'd0 && shf_field[2:1] == 2'b00) begin
            imm_lsl_zero_chk: assert (result == op_val && carry_out == carry_in);
        end
        // R7
        if (!shf_field[0] && shf_field[7:3] == 5'd0 && shf_field[2:1] == 2'b11) begin
            rrx_chk: assert (result == {carry_in, op_val[MSB:1]} && carry_out == op_val[0]);
        end
        // R9
        if (shf_field[0] && !shf_field[2] && rs_val[7:0] > 8'd32) begin
            logic_sat_chk: assert (result == '0 && !carry_out);
        end
        // R10
        if (shf_field[0] && shf_field[2:1] == 2'b10 && rs_val[7:0] >= 8'd32) begin
            asr_sat_chk: assert (result == {DATA_W{op_val[MSB]}} && carry_out == op_val[MSB]);
        end
    end

endmodule

bind opnd_shifter opnd_shifter_chk #(
    .DATA_W (DATA_W),
    .FLD_W  (FLD_W)
) u_chk (
    .op_val     (op_val),
    .shf_field  (shf_field),
    .rs_val     (rs_val),
    .carry_in   (carry_in),
    .result     (result),
    .carry_out  (carry_out),
    .rs_illegal (rs_illegal)
);

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_val;
    logic [7:0]  shf_field;
    logic [31:0] rs_val;
    logic        carry_in;
    logic [31:0] result;
    logic        carry_out;
    logic        rs_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    opnd_shifter u_opnd_shifter (
        .op_val     (op_val),
        .shf_field  (shf_field),
        .rs_val     (rs_val),
        .carry_in   (carry_in),
        .result     (result),
        .carry_out  (carry_out),
        .rs_illegal (rs_illegal)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cycles);
            report();
        end
    end

    // Bit-serial reference: moves one bit per step and tracks the bit that leaves.
    task automatic model(input logic [31:0] op, input logic [7:0] fld,
                         input logic [31:0] rs, input logic cin,
                         output logic [31:0] r, output logic c, output string tag);
        logic [1:0] kind;
        int         n;
        kind = fld[2:1];
        r    = op;
        c    = cin;
        if (!fld[0]) begin
            n = int'(fld[7:3]);
            if (n == 0) begin
                if (kind == 2'b00) begin tag = "R5"; return; end
                if (kind == 2'b11) begin
                    r = {cin, op[31:1]}; c = op[0]; tag = "R7"; return;
                end
                n = 32; tag = "R6";
            end else begin
                tag = (kind == 2'b00) ? "R2" : (kind == 2'b11) ? "R4" : "R3";
            end
        end else begin
            n = int'(rs[7:0]);
            if (n == 0) begin tag = "R8"; return; end
            if (kind == 2'b11)      tag = "R4";
            else if (n < 32)        tag = (kind == 2'b00) ? "R2" : "R3";
            else if (kind == 2'b10) tag = "R10";
            else                    tag = "R9";
        end
        for (int i = 0; i < n; i++) begin
            unique case (kind)
                2'b00: begin c = r[31]; r = {r[30:0], 1'b0}; end
                2'b01: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
                2'b11: begin c = r[0];  r = {r[0], r[31:1]}; end
            endcase
        end
    endtask

    task automatic apply(input logic [31:0] op, input logic [7:0] fld,
                         input logic [31:0] rs, input logic cin);
        logic [31:0] er;
        logic        ec;
        logic        ei;
        string       tag;
        @(posedge clk);
        op_val = op; shf_field = fld; rs_val = rs; carry_in = cin;
        model(op, fld, rs, cin, er, ec, tag);
        ei = fld[0] && (fld[7:4] == 4'hF);
        @(negedge clk);
        n_tests++;
        if (result !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s op=%h fld=%h rs=%h cin=%b: got %h/%b expected %h/%b",
                     tag, op, fld, rs, cin, result, carry_out, er, ec);
        end
        n_tests++;
        if (rs_illegal !== ei) begin
            n_fail++;
            $display("FAIL R11 fld=%h: got rs_illegal=%b expected %b", fld, rs_illegal, ei);
        end
    endtask

    logic [31:0] pats [6];
    int          amts [46];

    initial begin
        op_val = '0; shf_field = '0; rs_val = '0; carry_in = 1'b0;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
        pats[3] = 32'h7FFF_FFFE; pats[4] = 32'hA5C3_0F96; pats[5] = 32'h1234_5678;
        for (int i = 0; i < 41; i++) amts[i] = i;
        amts[41] = 63; amts[42] = 64; amts[43] = 96; amts[44] = 128; amts[45] = 255;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet inputs give a zero value, no carry and no illegal flag
        n_tests++;
        if (result !== 32'h0 || carry_out !== 1'b0 || rs_illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset-time: got %h/%b/%b expected 0/0/0",
                     result, carry_out, rs_illegal);
        end
        rst = 1'b0;
        for (int p = 0; p < 6; p++) begin
            for (int ci = 0; ci < 2; ci++) begin
                // Constant form: every amount and kind (R2-R7); junk in rs_val ignored (R1)
                for (int f = 0; f < 256; f += 2)
                    apply(pats[p], 8'(f), 32'hFFFF_FF1F, ci[0]);
                // Register form: index 3; high rs bytes are junk (R1, R4, R8-R10)
                for (int k = 0; k < 4; k++)
                    for (int a = 0; a < 46; a++)
                        apply(pats[p], {4'd3, 1'b0, 2'(k), 1'b1},
                              {24'hDE5A3C ^ 24'(p * 77), 8'(amts[a])}, ci[0]);
                // Register form with the program counter index: flag and shift together (R11)
                for (int k = 0; k < 4; k++)
                    for (int a = 0; a < 46; a += 5)
                        apply(pats[p], {4'hF, 1'b0, 2'(k), 1'b1},
                              {24'h13579B, 8'(amts[a])}, ci[0]);
            end
        end
        report();
    end

endmodule